// File: doc/BRIEF.md
# Character Command Responder

This block sits between the status strobes of a UART and its transmit data port. It takes one event at a time: a received character, or an error strobe from the receiver. It turns that event into one of six fixed four-byte ASCII replies and feeds the reply to the transmitter one byte at a time. The transmitter's transfer-end strobe paces the bytes.

A received upper-case command character is answered with "OK" followed by CR LF. The lower-case form is answered with "ok" CR LF. Any other character is answered with "UC" CR LF. A reception error is answered with a two-letter error code followed by CR LF.

While a reply is in flight the block raises a mask output and ignores new receive and error events. Reception is armed again only when the transfer-end of the last byte arrives. At that point a done flag rises. The serial framing, the baud clock and any bus access lie outside this block.

Top module: `cmdResponder`

## Requirements
- R1: A received character equal to CMD_UPPER (default 0x54) produces the reply bytes 0x4F, 0x4B, 0x0D, 0x0A, in that order.
- R2: A received character equal to CMD_LOWER (default 0x74) produces 0x6F, 0x6B, 0x0D, 0x0A.
- R3: Any other received character produces 0x55, 0x43, 0x0D, 0x0A.
- R4: An error strobe produces a reply that depends on the flag raised. A parity flag alone gives 0x50, 0x45, 0x0D, 0x0A. A framing flag alone gives 0x46, 0x45, 0x0D, 0x0A. An overrun flag alone gives 0x4F, 0x45, 0x0D, 0x0A.
- R5: When several error flags are raised together, only one reply is sent. Framing wins over parity, and parity wins over overrun.
- R6: An error strobe in the same cycle as a receive strobe is answered with the error reply only. The character is dropped and no character reply follows.
- R7: The first reply byte is presented with txLoad high in the cycle right after the event is accepted, and no transfer-end is needed for it. Each later byte is presented in the cycle after the transfer-end of the byte before it. txLoad is high for exactly one cycle per byte.
- R8: rxMask is high from the cycle after an event is accepted until the final transfer-end. While it is high, receive and error strobes are ignored. A transfer-end while no reply is in flight is also ignored.
- R9: On the final transfer-end, replyDone rises and rxMask falls, both in the next cycle. replyDone stays high until the next event is accepted.
- R10: After reset, txLoad, rxMask and replyDone are all low.
- R11: An error strobe with no error flag raised produces no reply and leaves rxMask low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Receive-end strobe: rxData holds one new character |
| rxData | input | 8 | Received character |
| errValid | input | 1 | Receive-error strobe |
| errFraming | input | 1 | Framing error flag, valid with errValid |
| errParity | input | 1 | Parity error flag, valid with errValid |
| errOverrun | input | 1 | Overrun error flag, valid with errValid |
| txEnd | input | 1 | Transfer-end strobe from the transmitter |
| txLoad | output | 1 | One-cycle strobe: load txData into the transmitter |
| txData | output | 8 | Reply byte to transmit |
| rxMask | output | 1 | High while a reply is in flight; events are ignored |
| replyDone | output | 1 | Set after the last reply byte has been sent |

## Verification
The bench builds the block with its default command characters, 0x54 and 0x74. It therefore also sends neighbouring values, such as the other letter case and unrelated characters, to reach the catch-all reply. The transmitter model answers with transfer-end latencies of one cycle and of several cycles. The short latency reaches the tightest load-to-load spacing, and the long latency leaves gaps in which events arrive while the reply is still in flight. Error strobes are driven with every combination of flags that matters for priority. They are also driven together with a receive strobe, and with no flag raised at all.

// File: rtl/rspPkg.sv
package rspPkg;
  localparam int CHAR_W      = 8;
  localparam int REPLY_BYTES = 4;
  localparam int IDX_W       = $clog2(REPLY_BYTES);

  typedef enum logic [2:0] {
    K_OK_UP = 3'd0,
    K_OK_LO = 3'd1,
    K_UC    = 3'd2,
    K_PE    = 3'd3,
    K_FE    = 3'd4,
    K_OE    = 3'd5
  } replyKindT;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOAD = 2'd1,
    S_WAIT = 2'd2
  } seqStateT;

  typedef struct packed {
    logic start;
    logic advance;
  } ctrlStrobeT;

  function automatic logic [CHAR_W-1:0] replyByte(replyKindT k, logic [IDX_W-1:0] i);
    logic [CHAR_W-1:0] b;
    case (i)
      2'd2: b = 8'h0D;
      2'd3: b = 8'h0A;
      2'd0: begin
        case (k)
          K_OK_UP: b = 8'h4F;
          K_OK_LO: b = 8'h6F;
          K_UC:    b = 8'h55;
          K_PE:    b = 8'h50;
          K_FE:    b = 8'h46;
          K_OE:    b = 8'h4F;
          default: b = 8'h3F;
        endcase
      end
      default: begin
        case (k)
          K_OK_UP: b = 8'h4B;
          K_OK_LO: b = 8'h6B;
          K_UC:    b = 8'h43;
          default: b = 8'h45;
        endcase
      end
    endcase
    return b;
  endfunction
endpackage

// File: rtl/rspDatapath.sv
module rspDatapath
  import rspPkg::*;
#(
  parameter logic [CHAR_W-1:0] CMD_UPPER = 8'h54,
  parameter logic [CHAR_W-1:0] CMD_LOWER = 8'h74
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              errValid,
  input  logic              errFraming,
  input  logic              errParity,
  input  logic              errOverrun,
  input  ctrlStrobeT        ctrl,
  output logic              evtReq,
  output logic              isLast,
  output logic [CHAR_W-1:0] txData
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REPLY_BYTES - 1);

  replyKindT        nextKind;
  replyKindT        kindQ;
  logic [IDX_W-1:0] idxQ;
  logic             anyErr;

  assign anyErr = errFraming | errParity | errOverrun;

  // Error path has precedence; an error drops any character in the same cycle.
  always_comb begin
    nextKind = K_UC;
    evtReq   = 1'b0;
    if (errValid) begin
      evtReq = anyErr;
      if (errFraming)      nextKind = K_FE;
      else if (errParity)  nextKind = K_PE;
      else                 nextKind = K_OE;
    end else if (rxValid) begin
      evtReq = 1'b1;
      if (rxData == CMD_UPPER)      nextKind = K_OK_UP;
      else if (rxData == CMD_LOWER) nextKind = K_OK_LO;
      else                          nextKind = K_UC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ <= K_UC;
      idxQ  <= '0;
    end else if (ctrl.start) begin
      kindQ <= nextKind;
      idxQ  <= '0;
    end else if (ctrl.advance) begin
      idxQ  <= idxQ + 1'b1;
    end
  end

  assign isLast = (idxQ == LAST_IDX);
  assign txData = replyByte(kindQ, idxQ);

  a_r7_index_restart: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.start |=> (idxQ == '0));
  a_r7_index_step: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.advance |=> (idxQ == $past(idxQ) + 1'b1));
  a_r5_framing_first: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.start && errValid && errFraming) |=> (kindQ == K_FE));
  a_r6_error_wins: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.start && errValid) |=> (kindQ == K_FE || kindQ == K_PE || kindQ == K_OE));
endmodule

// File: rtl/rspControl.sv
module rspControl
  import rspPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evtReq,
  input  logic       isLast,
  input  logic       txEnd,
  output ctrlStrobeT ctrl,
  output logic       txLoad,
  output logic       rxMask,
  output logic       replyDone
);
  seqStateT stateQ, stateD;
  logic     finish;

  assign ctrl.start   = (stateQ == S_IDLE) && evtReq;
  assign ctrl.advance = (stateQ == S_WAIT) && txEnd && !isLast;
  assign finish       = (stateQ == S_WAIT) && txEnd && isLast;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      S_IDLE: if (evtReq) stateD = S_LOAD;
      S_LOAD: stateD = S_WAIT;
      S_WAIT: if (txEnd) stateD = isLast ? S_IDLE : S_LOAD;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= S_IDLE;
      replyDone <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (ctrl.start)  replyDone <= 1'b0;
      else if (finish) replyDone <= 1'b1;
    end
  end

  assign txLoad = (stateQ == S_LOAD);
  assign rxMask = (stateQ != S_IDLE);

  a_r8_mask_on_load: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |-> rxMask);
  a_r7_single_load: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> !txLoad);
  a_r7_first_load: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.start |=> txLoad);
  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    rxMask |-> !ctrl.start);
  a_r9_done_unmasks: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> (replyDone && !rxMask));
endmodule

// File: rtl/cmdResponder.sv
module cmdResponder
  import rspPkg::*;
#(
  parameter logic [7:0] CMD_UPPER = 8'h54,
  parameter logic [7:0] CMD_LOWER = 8'h74
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       errValid,
  input  logic       errFraming,
  input  logic       errParity,
  input  logic       errOverrun,
  input  logic       txEnd,
  output logic       txLoad,
  output logic [7:0] txData,
  output logic       rxMask,
  output logic       replyDone
);
  ctrlStrobeT ctrl;
  logic       evtReq;
  logic       isLast;

  rspDatapath #(.CMD_UPPER(CMD_UPPER), .CMD_LOWER(CMD_LOWER)) dp_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .errValid(errValid), .errFraming(errFraming), .errParity(errParity),
    .errOverrun(errOverrun), .ctrl(ctrl), .evtReq(evtReq), .isLast(isLast),
    .txData(txData)
  );

  rspControl ctl_i (
    .clk(clk), .rstN(rstN), .evtReq(evtReq), .isLast(isLast), .txEnd(txEnd),
    .ctrl(ctrl), .txLoad(txLoad), .rxMask(rxMask), .replyDone(replyDone)
  );
endmodule

// File: tb/cmdResponder_tb.sv
module cmdResponder_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic       errValid = 1'b0;
  logic       errFraming = 1'b0;
  logic       errParity = 1'b0;
  logic       errOverrun = 1'b0;
  logic       modelEnd = 1'b0;
  logic       spuriousEnd = 1'b0;
  logic       txEnd;
  logic       txLoad;
  logic [7:0] txData;
  logic       rxMask;
  logic       replyDone;

  int         checks = 0;
  int         fails = 0;
  int         txLat = 1;
  int         byteCnt = 0;
  bit         summaryDone = 1'b0;
  string      curReq = "R10";
  logic [7:0] expQ[$];

  assign txEnd = modelEnd | spuriousEnd;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdResponder dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .errValid(errValid), .errFraming(errFraming), .errParity(errParity),
    .errOverrun(errOverrun), .txEnd(txEnd), .txLoad(txLoad), .txData(txData),
    .rxMask(rxMask), .replyDone(replyDone)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every byte the design loads.
  always @(negedge clk) begin
    if (rstN && txLoad) begin
      if (expQ.size() == 0) chk(1'b0, "R8", "unexpected reply byte", txData, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        chk(txData == e, curReq, "reply byte", txData, e);
      end
    end
  end

  // Transmitter model: answers each load with a transfer-end after txLat cycles.
  initial begin
    forever begin
      @(negedge clk);
      while (rstN && txLoad) begin
        repeat (txLat) @(negedge clk);
        modelEnd = 1'b1;
        @(negedge clk);
        modelEnd = 1'b0;
        byteCnt++;
        if (byteCnt % 4 != 0) begin
          chk(txLoad == 1'b1, "R7", "next byte after transfer-end", txLoad, 1);
        end else begin
          chk(txLoad == 1'b0, "R7", "no load after last byte", txLoad, 0);
          chk(replyDone == 1'b1, "R9", "done after last byte", replyDone, 1);
          chk(rxMask == 1'b0, "R9", "mask falls after last byte", rxMask, 0);
        end
      end
    end
  end

  task automatic pushReply(logic [7:0] a, logic [7:0] b);
    expQ.push_back(a);
    expQ.push_back(b);
    expQ.push_back(8'h0D);
    expQ.push_back(8'h0A);
  endtask

  task automatic waitIdle();
    while (rxMask) @(negedge clk);
  endtask

  task automatic fire(string req, bit rv, logic [7:0] c, bit ev, bit f, bit p, bit o,
                      logic [7:0] a, logic [7:0] b);
    curReq = req;
    pushReply(a, b);
    @(negedge clk);
    rxValid = rv; rxData = c;
    errValid = ev; errFraming = f; errParity = p; errOverrun = o;
    @(negedge clk);
    rxValid = 1'b0; errValid = 1'b0;
    errFraming = 1'b0; errParity = 1'b0; errOverrun = 1'b0;
    chk(txLoad == 1'b1, "R7", "first byte without transfer-end", txLoad, 1);
    chk(rxMask == 1'b1, "R8", "mask raised after accept", rxMask, 1);
    chk(replyDone == 1'b0, "R9", "done cleared on new event", replyDone, 0);
    waitIdle();
    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, req, "reply fully sent", expQ.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(txLoad == 1'b0, "R10", "txLoad in reset", txLoad, 0);
    chk(rxMask == 1'b0, "R10", "rxMask in reset", rxMask, 0);
    chk(replyDone == 1'b0, "R10", "replyDone in reset", replyDone, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    txLat = 1;
    fire("R1", 1, 8'h54, 0, 0, 0, 0, 8'h4F, 8'h4B);
    fire("R2", 1, 8'h74, 0, 0, 0, 0, 8'h6F, 8'h6B);
    fire("R3", 1, 8'h41, 0, 0, 0, 0, 8'h55, 8'h43);
    txLat = 3;
    fire("R3", 1, 8'h55, 0, 0, 0, 0, 8'h55, 8'h43);
    fire("R4", 0, 8'h00, 1, 0, 1, 0, 8'h50, 8'h45);
    fire("R4", 0, 8'h00, 1, 1, 0, 0, 8'h46, 8'h45);
    fire("R4", 0, 8'h00, 1, 0, 0, 1, 8'h4F, 8'h45);
    fire("R5", 0, 8'h00, 1, 1, 1, 1, 8'h46, 8'h45);
    fire("R5", 0, 8'h00, 1, 0, 1, 1, 8'h50, 8'h45);
    fire("R6", 1, 8'h54, 1, 0, 1, 0, 8'h50, 8'h45);

    // R11: error strobe with no flag raised
    curReq = "R11";
    @(negedge clk);
    errValid = 1'b1;
    @(negedge clk);
    errValid = 1'b0;
    chk(txLoad == 1'b0, "R11", "no load for empty error", txLoad, 0);
    chk(rxMask == 1'b0, "R11", "mask stays low", rxMask, 0);
    chk(replyDone == 1'b1, "R11", "done flag unchanged", replyDone, 1);

    // R8: events during a reply are ignored
    curReq = "R8";
    txLat = 4;
    pushReply(8'h4F, 8'h4B);
    @(negedge clk);
    rxValid = 1'b1; rxData = 8'h54;
    @(negedge clk);
    rxValid = 1'b0;
    repeat (2) @(negedge clk);
    rxValid = 1'b1; rxData = 8'h74;
    errValid = 1'b1; errFraming = 1'b1;
    @(negedge clk);
    rxValid = 1'b0; errValid = 1'b0; errFraming = 1'b0;
    waitIdle();
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R8", "only the first reply sent", expQ.size(), 0);
    chk(rxMask == 1'b0, "R8", "no reply after ignored events", rxMask, 0);

    // R8: transfer-end while idle is ignored
    spuriousEnd = 1'b1;
    @(negedge clk);
    spuriousEnd = 1'b0;
    chk(txLoad == 1'b0, "R8", "idle transfer-end ignored", txLoad, 0);
    chk(rxMask == 1'b0, "R8", "idle transfer-end keeps mask low", rxMask, 0);
    fire("R1", 1, 8'h54, 0, 0, 0, 0, 8'h4F, 8'h4B);

    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!summaryDone) begin
      summaryDone = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired during %s actual=0 expected=1", curReq);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule